// File: doc/BRIEF.md
# Prioritized Interrupt Level Recognizer

This block watches a three-wire, active-low encoded interrupt request and decides when the processor side should take an interrupt. Each line passes through a synchronizer. The decoded level must then agree on two consecutive samples before it counts. The block compares the filtered level with a 3-bit priority mask. Levels 1 to 6 are recognized only when they stand above the mask. The top level (7) cannot be masked: every rise into it from a lower level is latched as a sticky event, and that event stays pending until it is acknowledged.

The consumer sees a pending flag and the pending level. When it takes the interrupt, it returns a one-cycle acknowledge, and the mask then rises to the accepted level. A separate mask write port stands in for software changing the mask or returning from a handler. Lowering the mask below a request that is still held produces a new recognition through the normal comparison, and this includes a held level 7.

Top module: `irq_level_recognizer`

## Requirements
- R1: The request level is the bitwise inverse of `irq_n` read as a binary number. `3'b111` means level 0 (no request) and `3'b000` means level 7.
- R2: A new value on `irq_n` reaches the outputs after the fourth rising edge, counting from its first sampling edge. That is two synchronizer edges, one candidate edge and one filter edge. A value held for a single cycle is ignored.
- R3: While no level-7 event is latched, `int_pending` is 1 only if the filtered level is strictly greater than `mask_level`. In that case `int_level` gives the filtered level.
- R4: A change of the filtered level from any value below 7 to 7 latches a level-7 event, whatever the mask. This includes a mask of 7. A latched event drives `int_pending`=1 and `int_level`=7.
- R5: When `int_ack` is 1 while `int_pending` is 1, `mask_level` loads `int_level` on that edge.
- R6: Acknowledging level 7 clears the latched level-7 event. A request then held at 7 with a mask of 7 stays quiet.
- R7: When `mask_we` writes a value below a held request level, that level becomes pending. This also holds for level 7.
- R8: If an accepted acknowledge and a mask write fall on the same edge, the mask takes the acknowledged level.
- R9: After reset, `mask_level` is 7 and nothing is pending. A request held at 7 through reset creates no level-7 event.
- R10: When nothing is pending, `int_level` is 0. An `int_ack` while nothing is pending leaves the mask unchanged.
- R11: A latched level-7 event stays pending until it is acknowledged, even if the request falls away.
- R12: After a level is acknowledged, that level stays masked when the request drops to a lower level and returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 3 | Active-low encoded request level, asynchronous |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 3 | Value written to the mask |
| int_ack | input | 1 | One-cycle acknowledge of the pending interrupt |
| int_pending | output | 1 | An interrupt is recognized and waiting |
| int_level | output | 3 | Level of the pending interrupt, 0 when none |
| mask_level | output | 3 | Current priority mask |

## Verification
The bench samples one cycle before and one cycle after the expected latency. An extra or missing pipeline stage shows up as a flag that is early or late. A one-cycle glitch is driven into an idle request; a design without the two-sample match would raise a false interrupt. The level-7 cases use a mask of 7: a drop to level 3 and a return must fire again, a held 7 after acknowledge must stay silent, and lowering the mask must fire by comparison. A design that treated level 7 as level-sensitive, or that never cleared the sticky event, would fail one of these. A same-cycle acknowledge and mask write, and a request held at 7 across reset, catch a reversed priority and a spurious reset edge.

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer #(
  parameter int LW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] irq_n,
  input  logic          mask_we,
  input  logic [LW-1:0] mask_wdata,
  input  logic          int_ack,
  output logic          int_pending,
  output logic [LW-1:0] int_level,
  output logic [LW-1:0] mask_level
);

  localparam logic [LW-1:0] TOP = '1;

  logic [LW-1:0] stg [SYNC_STAGES];

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= irq_n;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  logic [LW-1:0] dec_lvl, cand_q, filt_q, mask_q;
  logic          edge_q;

  assign dec_lvl = ~stg[SYNC_STAGES-1];

  wire filt_ld  = (dec_lvl == cand_q);
  wire edge_set = filt_ld && (dec_lvl == TOP) && (filt_q != TOP);
  wire lvl_hit  = filt_q > mask_q;
  wire accept   = int_ack && int_pending;

  assign int_pending = edge_q || lvl_hit;
  assign int_level   = edge_q ? TOP : (lvl_hit ? filt_q : '0);
  assign mask_level  = mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cand_q <= TOP;
      filt_q <= TOP;
    end else begin
      cand_q <= dec_lvl;
      if (filt_ld) filt_q <= dec_lvl;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        edge_q <= 1'b0;
    else if (edge_set)                 edge_q <= 1'b1;
    else if (accept && int_level == TOP) edge_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= TOP;
    else if (accept)  mask_q <= int_level;
    else if (mask_we) mask_q <= mask_wdata;

endmodule

// File: rtl/irq_level_recognizer_chk.sv
module irq_level_recognizer_chk #(
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mask_we,
  input logic [LW-1:0] mask_wdata,
  input logic          int_ack,
  input logic          int_pending,
  input logic [LW-1:0] int_level,
  input logic [LW-1:0] mask_level
);

  localparam logic [LW-1:0] TOP = '1;

  assert_masked_compare_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pending && int_level != TOP) |-> (int_level > mask_level));

  assert_ack_loads_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_pending) |=> (mask_level == $past(int_level)));

  assert_ack_beats_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_pending && mask_we) |=> (mask_level == $past(int_level)));

  assert_write_loads_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !(int_ack && int_pending)) |=> (mask_level == $past(mask_wdata)));

  assert_idle_level_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_pending |-> (int_level == '0));

  assert_mask_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(int_ack && int_pending) && !mask_we) |=> $stable(mask_level));

  assert_top_event_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pending && int_level == TOP && mask_level == TOP && !int_ack)
      |=> (int_pending && int_level == TOP));

endmodule

bind irq_level_recognizer irq_level_recognizer_chk #(.LW(LW)) u_chk (.*);

// File: tb/tb_irq_level_recognizer.sv
module tb_irq_level_recognizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] irq_n = 3'b000;
  logic       mask_we = 1'b0;
  logic [2:0] mask_wdata = '0;
  logic       int_ack = 1'b0;
  logic       int_pending;
  logic [2:0] int_level, mask_level;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_level_recognizer dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(string req, int pend, int lvl, int msk);
    chk(req, "pending", int_pending, pend);
    chk(req, "level", int_level, lvl);
    chk(req, "mask", mask_level, msk);
  endtask

  task automatic set_req(int lvl);
    @(negedge clk); irq_n = ~lvl[2:0];
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_mask(int v);
    @(negedge clk); mask_we = 1'b1; mask_wdata = v[2:0];
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic ack_and_write(int v);
    @(negedge clk); int_ack = 1'b1; mask_we = 1'b1; mask_wdata = v[2:0];
    @(negedge clk); int_ack = 1'b0; mask_we = 1'b0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset_held_top();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_out("R9", 0, 0, 7);
    set_req(0); settle();
    expect_out("R9", 0, 0, 7);
  endtask

  task automatic t_idle_ack();
    wr_mask(0);
    expect_out("R10", 0, 0, 0);
    do_ack();
    expect_out("R10", 0, 0, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk); irq_n = ~3'd5;
    @(negedge clk); irq_n = 3'b111;
    settle();
    expect_out("R2", 0, 0, 0);
  endtask

  task automatic t_latency();
    set_req(3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2", "pending before latency", int_pending, 0);
    @(posedge clk); @(negedge clk);
    chk("R2", "pending at latency", int_pending, 1);
    chk("R1", "decoded level", int_level, 3);
  endtask

  task automatic t_ack_masks_same_level();
    do_ack();
    expect_out("R5", 0, 0, 3);
    set_req(0); settle();
    set_req(3); settle();
    expect_out("R12", 0, 0, 3);
  endtask

  task automatic t_compare_and_write();
    set_req(5); settle();
    expect_out("R3", 1, 5, 3);
    wr_mask(6);
    expect_out("R3", 0, 0, 6);
    wr_mask(4);
    expect_out("R7", 1, 5, 4);
    ack_and_write(1);
    expect_out("R8", 0, 0, 5);
  endtask

  task automatic t_top_edges();
    set_req(7); settle();
    expect_out("R1", 1, 7, 5);
    do_ack();
    expect_out("R6", 0, 0, 7);
    set_req(3); settle();
    set_req(7); settle();
    expect_out("R4", 1, 7, 7);
    set_req(0); settle();
    expect_out("R11", 1, 7, 7);
    do_ack();
    expect_out("R6", 0, 0, 7);
    set_req(7); settle();
    do_ack(); settle();
    expect_out("R6", 0, 0, 7);
    wr_mask(2);
    expect_out("R7", 1, 7, 2);
    do_ack();
    expect_out("R5", 0, 0, 7);
  endtask

  initial begin
    t_reset_held_top();
    t_idle_ack();
    t_glitch();
    t_latency();
    t_ack_masks_same_level();
    t_compare_and_write();
    t_top_edges();
    report();
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule